// File: doc/BRIEF.md
# Rising-Edge Pulse Amplitude Extractor

This block estimates the height of a pulse in a stream of smoothed, signed samples. For every accepted sample it forms a lagged difference: the current sample minus the sample received `LAG` valid samples earlier. Only the non-negative part of that difference counts. A difference of zero or below adds nothing, and a positive difference adds its own value. The block sums these contributions over a window of `WIN_N+1` consecutive differences. As a result the estimate follows the rising edge of a pulse, ignores its falling edge, and does not depend on a constant baseline. No separate baseline estimator is needed.

A window opens when a difference exceeds the threshold input and no window is already open. That opening difference is the first of the window. Every following difference goes into the same window until `WIN_N+1` differences have been taken. The sum is then presented on the amplitude output together with a one-cycle valid pulse. A one-cycle hit flag marks each window start. A new window can open from the next difference after a window closes.

For an ideal step of height H, the lagged difference equals H for exactly `LAG` differences. The reported amplitude is therefore `LAG*H`, on any baseline, as long as the window holds at least `LAG` differences.

Top module: `edge_amp_extractor`

## Requirements
- R1: After reset, `ampValid` and `hitFlag` are low and `ampOut` is zero. No window is open.
- R2: The first `LAG` valid samples after reset form no difference. No window can open from them, whatever their values.
- R3: The difference is `sampleIn` minus the sample accepted `LAG` valid samples earlier. Cycles with `sampleValid` low change nothing and do not advance the lag.
- R4: A window opens only when a difference is strictly greater than the signed `thrIn` and no window is open. A difference equal to the threshold opens nothing. `hitFlag` is high for exactly the one cycle after the clock edge that accepted the opening difference.
- R5: A window takes exactly `WIN_N+1` differences, counting the opening one. `ampValid` is high for one cycle after the edge that accepted the last of them. Every window produces exactly one result.
- R6: `ampOut` is the sum of max(D,0) over the window's differences. Negative and zero differences add nothing, so a falling edge adds nothing.
- R7: A step of height H gives `LAG*H`, the same value on any constant baseline.
- R8: Differences that arrive while a window is open join that window. The difference right after a window closes may open the next window, so a steady ramp produces windows back to back.
- R9: `ampOut` (`SAMPLE_W+clog2(WIN_N+1)+1` bits, unsigned) holds full-scale swings without wrapping. For example, a jump from the most negative to the most positive sample gives `LAG*(2^SAMPLE_W-1)`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleIn | input | SAMPLE_W | Signed smoothed sample |
| sampleValid | input | 1 | Qualifies `sampleIn` |
| thrIn | input | SAMPLE_W+1 | Signed window-open threshold |
| ampOut | output | SAMPLE_W+clog2(WIN_N+1)+1 | Amplitude of the last closed window |
| ampValid | output | 1 | One-cycle strobe for `ampOut` |
| hitFlag | output | 1 | One-cycle strobe when a window opens |

## Verification
A corrupted lag line or fill count shows up as a wrong amplitude, or as a spurious or missing hit. This is visible one cycle after the affected difference is accepted, or at the latest when the window closes, `WIN_N+1` valid samples later. A wrong window counter shifts the `ampValid` pulse or merges two windows, so the result order in the scoreboard breaks at the next close. Steps on different baselines, gapped input, threshold-equal differences, continuous ramps and full-scale jumps each stress a different part of the sum.

// File: rtl/edge_amp_pkg.sv
package edge_amp_pkg;
  // Strobes from window control into the datapath
  typedef struct packed {
    logic startWin;  // accepted difference opens a window
    logic addDiff;   // accepted difference belongs to the window
    logic lastDiff;  // accepted difference closes the window
  } winStrobeT;
endpackage

// File: rtl/edge_amp_datapath.sv
module edge_amp_datapath
  import edge_amp_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int LAG      = 4,
  parameter int WIN_N    = 7,
  localparam int DIFF_W  = SAMPLE_W + 1,
  localparam int ACC_W   = SAMPLE_W + $clog2(WIN_N + 1) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                sampleValid,
  input  logic [DIFF_W-1:0]   thrIn,
  input  winStrobeT           strb,
  output logic                diffAbove,
  output logic [ACC_W-1:0]    ampOut,
  output logic                ampValid
);
  logic [SAMPLE_W-1:0] dly [LAG];
  logic [DIFF_W-1:0]   diff;
  logic [ACC_W-1:0]    posPart;
  logic [ACC_W-1:0]    acc;

  // Lag line: dly[LAG-1] holds the sample LAG valid samples back
  for (genvar i = 0; i < LAG; i++) begin : g_lag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dly[i] <= '0;
      end else if (sampleValid) begin
        if (i == 0) dly[i] <= sampleIn;
        else        dly[i] <= dly[(i == 0) ? 0 : i - 1];
      end
    end
  end

  always_comb begin
    diff      = {sampleIn[SAMPLE_W-1], sampleIn} - {dly[LAG-1][SAMPLE_W-1], dly[LAG-1]};
    diffAbove = $signed(diff) > $signed(thrIn);
    posPart   = diff[DIFF_W-1] ? '0 : {{(ACC_W-DIFF_W){1'b0}}, diff};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc      <= '0;
      ampOut   <= '0;
      ampValid <= 1'b0;
    end else begin
      ampValid <= strb.lastDiff;
      if (strb.startWin)     acc <= posPart;
      else if (strb.addDiff) acc <= acc + posPart;
      if (strb.lastDiff)     ampOut <= (strb.startWin ? '0 : acc) + posPart;
    end
  end

  // R6: contributions are never negative, so the running sum never falls
  a_r6_acc_never_drops: assert property (@(posedge clk) disable iff (!rstN)
    (strb.addDiff && !strb.startWin) |=> (acc >= $past(acc)));

  // R5: the emitted amplitude is at least the sum gathered before the closing difference
  a_r5_amp_covers_sum: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lastDiff && !strb.startWin) |=> (ampOut >= $past(acc)));

  // R3: the lag line holds still while no valid sample arrives
  a_r3_lag_holds: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(dly[LAG-1]));
endmodule

// File: rtl/edge_amp_ctrl.sv
module edge_amp_ctrl
  import edge_amp_pkg::*;
#(
  parameter int LAG   = 4,
  parameter int WIN_N = 7,
  localparam int FILL_W = $clog2(LAG + 1),
  localparam int CNT_W  = $clog2(WIN_N + 1)
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleValid,
  input  logic      diffAbove,
  output winStrobeT strb,
  output logic      hitFlag
);
  logic [FILL_W-1:0] fillCnt;
  logic              filled;
  logic              open;
  logic [CNT_W-1:0]  cnt;   // differences already taken in the open window
  logic              diffValid;

  always_comb begin
    filled        = (fillCnt == FILL_W'(LAG));
    diffValid     = sampleValid && filled;
    strb.startWin = diffValid && !open && diffAbove;
    strb.addDiff  = strb.startWin || (diffValid && open);
    strb.lastDiff = diffValid && open && (cnt == CNT_W'(WIN_N));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCnt <= '0;
      open    <= 1'b0;
      cnt     <= '0;
      hitFlag <= 1'b0;
    end else begin
      hitFlag <= strb.startWin;
      if (sampleValid && !filled) fillCnt <= fillCnt + 1'b1;
      if (strb.startWin) begin
        open <= 1'b1;
        cnt  <= CNT_W'(1);
      end else if (strb.lastDiff) begin
        open <= 1'b0;
        cnt  <= '0;
      end else if (strb.addDiff) begin
        cnt  <= cnt + 1'b1;
      end
    end
  end

  // R8: no second window while one is open
  a_r8_single_window: assert property (@(posedge clk) disable iff (!rstN)
    open |-> !strb.startWin);

  // R5: the count stays inside the window length
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    open |-> (cnt >= CNT_W'(1) && cnt <= CNT_W'(WIN_N)));

  // R2: nothing is accumulated before the lag line is full
  a_r2_fill_gate: assert property (@(posedge clk) disable iff (!rstN)
    !filled |-> !strb.addDiff);

  // R4: the hit flag is a single-cycle pulse
  a_r4_hit_pulse: assert property (@(posedge clk) disable iff (!rstN)
    hitFlag |=> !hitFlag);
endmodule

// File: rtl/edge_amp_extractor.sv
module edge_amp_extractor
  import edge_amp_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int LAG      = 4,
  parameter int WIN_N    = 7,
  localparam int DIFF_W  = SAMPLE_W + 1,
  localparam int ACC_W   = SAMPLE_W + $clog2(WIN_N + 1) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                sampleValid,
  input  logic [DIFF_W-1:0]   thrIn,
  output logic [ACC_W-1:0]    ampOut,
  output logic                ampValid,
  output logic                hitFlag
);
  winStrobeT strb;
  logic      diffAbove;

  edge_amp_ctrl #(.LAG(LAG), .WIN_N(WIN_N)) ctrl_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .diffAbove(diffAbove), .strb(strb), .hitFlag(hitFlag)
  );

  edge_amp_datapath #(.SAMPLE_W(SAMPLE_W), .LAG(LAG), .WIN_N(WIN_N)) dp_i (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .thrIn(thrIn), .strb(strb), .diffAbove(diffAbove),
    .ampOut(ampOut), .ampValid(ampValid)
  );
endmodule

// File: tb/edge_amp_extractor_tb_top.sv
module edge_amp_extractor_tb_top;
  localparam int SAMPLE_W = 16;
  localparam int LAG      = 4;
  localparam int WIN_N    = 7;
  localparam int DIFF_W   = SAMPLE_W + 1;
  localparam int ACC_W    = SAMPLE_W + $clog2(WIN_N + 1) + 1;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [SAMPLE_W-1:0] sampleIn = '0;
  logic                sampleValid = 1'b0;
  logic [DIFF_W-1:0]   thrIn = '0;
  logic [ACC_W-1:0]    ampOut;
  logic                ampValid;
  logic                hitFlag;

  always #10 clk = ~clk;

  edge_amp_extractor #(.SAMPLE_W(SAMPLE_W), .LAG(LAG), .WIN_N(WIN_N)) dut_i (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .thrIn(thrIn), .ampOut(ampOut), .ampValid(ampValid), .hitFlag(hitFlag)
  );

  int    checks = 0;
  int    failures = 0;
  string curReq = "R1";
  int    ampQ[$];
  string reqQ[$];
  bit    expHit = 1'b0;
  bit    done = 1'b0;

  // Reference model state, built from the requirements
  int hist[$];
  bit mOpen = 1'b0;
  int mCnt = 0;
  int mAcc = 0;
  int thr = 100;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of input and updates the expected results
  task automatic drive(input int val, input bit vld);
    int d;
    @(negedge clk);
    sampleIn    = SAMPLE_W'(val);
    sampleValid = vld;
    thrIn       = DIFF_W'(thr);
    expHit      = 1'b0;
    if (vld) begin
      if (hist.size() >= LAG) begin
        d = val - hist[hist.size() - LAG];
        if (!mOpen) begin
          if (d > thr) begin
            mOpen  = 1'b1;
            mCnt   = 1;
            mAcc   = (d > 0) ? d : 0;
            expHit = 1'b1;
          end
        end else begin
          mAcc += (d > 0) ? d : 0;
          mCnt++;
          if (mCnt == WIN_N + 1) begin
            ampQ.push_back(mAcc);
            reqQ.push_back(curReq);
            mOpen = 1'b0;
          end
        end
      end
      hist.push_back(val);
      if (hist.size() > LAG) void'(hist.pop_front());
    end
  endtask

  task automatic hold(input int val, input int n);
    for (int i = 0; i < n; i++) drive(val, 1'b1);
  endtask

  // Monitor: compares outputs against the scoreboard after each edge
  initial forever begin
    @(posedge clk);
    #2;
    if (rstN && !done) begin
      check(hitFlag == expHit, curReq, "hitFlag", int'(hitFlag), int'(expHit));
      if (ampValid) begin
        if (ampQ.size() == 0) begin
          check(1'b0, curReq, "unexpected ampValid ampOut", int'(ampOut), -1);
        end else begin
          int e;
          string r;
          e = ampQ.pop_front();
          r = reqQ.pop_front();
          check(int'(ampOut) == e, r, "ampOut", int'(ampOut), e);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    curReq = "R1";
    check(ampValid == 1'b0, "R1", "ampValid after reset", int'(ampValid), 0);
    check(hitFlag == 1'b0, "R1", "hitFlag after reset", int'(hitFlag), 0);
    check(ampOut == '0, "R1", "ampOut after reset", int'(ampOut), 0);

    // R2: wild fill values, no window may open from them
    curReq = "R2";
    drive(10000, 1); drive(-20000, 1); drive(30000, 1); drive(-30000, 1);
    hold(500, 16);

    // R7: step of 1000 on two baselines, expected 4000 each
    curReq = "R7";
    hold(1500, 12);
    check(ampQ.size() == 0, "R7", "pending results", ampQ.size(), 0);
    hold(-3000, 16);
    hold(-2000, 12);

    // R6: rise then fall inside one window
    curReq = "R6";
    hold(0, 8);
    for (int i = 1; i <= 5; i++) drive(i * 300, 1);
    for (int i = 4; i >= 0; i--) drive(i * 300, 1);
    hold(0, 12);

    // R3: gapped input with junk on invalid cycles
    curReq = "R3";
    for (int i = 0; i < 6; i++) begin drive(700, 1); drive(-32000, 0); drive(12345, 0); end
    for (int i = 0; i < 6; i++) begin drive(1900, 1); drive(31000, 0); end
    hold(1900, 10);

    // R4: difference equal to the threshold opens nothing; one above does
    curReq = "R4";
    hold(2000, 6);
    hold(2100, 12);
    check(ampQ.size() == 0, "R4", "results from equal-threshold step", ampQ.size(), 0);
    hold(2201, 12);

    // R8: steady ramp, back-to-back windows
    curReq = "R8";
    for (int i = 0; i < 40; i++) drive(2201 + i * 50, 1);
    hold(4151, 12);

    // R6: negative threshold on a flat line gives zero amplitudes
    curReq = "R6";
    thr = -5;
    hold(4151, 20);
    thr = 100;
    hold(4151, 12);

    // R9: full-scale jump, expected 4*65535
    curReq = "R9";
    hold(-32768, 10);
    hold(32767, 10);
    hold(-32768, 10);
    hold(-32768, 4);

    repeat (4) drive(0, 0);
    check(ampQ.size() == 0, "R5", "results never produced", ampQ.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule